// File: doc/BRIEF.md
# VCLK-Paced Serial Byte Streamer

This block sends the contents of a small byte array out on a serial data line with no host addressing. A separate slow clock, VCLK, paces it: each rising edge moves the output by one bit slot. The block runs on the system clock. It sees VCLK as an already synchronized level and finds the rising edges in the system clock domain.

When the mode controller asserts the enable, the block first counts a fixed number of VCLK rising edges while the data line stays released. After that it streams the array from address 0 upward. Each byte goes out most significant bit first and is followed by one slot in which the line is released. The address wraps from the last location back to 0. The controller holds the enable only while the serial clock line of the bidirectional bus stays high. Dropping the enable releases the line and clears the position, so the next entry repeats the synchronizing run.

The array is shared with other paths and is reached through a read port. The block drives the address, and the read data must be valid in the same system clock cycle.

Top module: `vclk_stream_tx`

## Requirements
- R1: During and straight after reset, `sda_oe_o` is 0, `sda_o` is 1 and `rd_addr_o` is 0.
- R2: After the enable rises, the first INIT_PULSES (default 9) rising VCLK edges leave `sda_oe_o` at 0.
- R3: On the next rising VCLK edge (the 10th by default), `sda_oe_o` becomes 1 and `sda_o` carries bit 7 of the byte at address 0. The output register updates one system clock after the edge is seen.
- R4: The eight data slots of a byte carry its bits in the order 7 down to 0, one per rising VCLK edge, and `rd_addr_o` holds that byte's address for the whole byte.
- R5: The ninth rising VCLK edge of each byte is a don't-care slot: `sda_oe_o` goes to 0 and `sda_o` to 1.
- R6: On the don't-care edge, `rd_addr_o` advances by exactly one. It changes at no other time while enabled.
- R7: After the byte at address DEPTH-1 (default 127), the address rolls over to 0 and the byte at address 0 is sent again.
- R8: Outside a rising VCLK edge, including on a falling VCLK edge, `sda_o` and `sda_oe_o` hold their values while enabled.
- R9: When `en_i` is 0 at a clock edge, `sda_oe_o` is 0 after that edge, and the slot count and address are cleared. A later re-entry repeats the full synchronizing run and restarts at address 0.
- R10: VCLK pulses while `en_i` is 0 have no effect: the line stays released and `rd_addr_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vclk_i | input | 1 | Synchronized VCLK level |
| en_i | input | 1 | Mode enable from the mode controller |
| rd_data_i | input | DATA_W | Array read data for `rd_addr_o`, valid in the same cycle |
| rd_addr_o | output | ADDR_W | Array read address |
| sda_o | output | 1 | Data line drive value |
| sda_oe_o | output | 1 | Data line output enable; 0 releases the line |

## Verification
The array model gives every address a distinct byte with mixed high and low bits. A bit-order or slot-offset error therefore shows up as a wrong `sda_o` value, and a pulse missing from the synchronizing run shows up one slot early. Several bytes are streamed in a row, then the full array is run through to test rollover, where an off-by-one in the wrap limit shows up as a wrong address or byte. The enable is dropped in the middle of a byte and VCLK is pulsed while disabled. This separates a state that is truly cleared from one that is only gated, because after re-entry the output must again wait the full synchronizing run and restart at address 0. Every pulse is also re-sampled after its falling edge, which catches designs that react to the wrong VCLK edge.

// File: rtl/vst_pkg.sv
package vst_pkg;

  typedef enum logic {
    PH_SYNC   = 1'b0,
    PH_STREAM = 1'b1
  } vst_phase_e;

  typedef struct packed {
    logic oe;
    logic val;
  } vst_drive_t;

  localparam vst_drive_t DRIVE_RELEASED = '{oe: 1'b0, val: 1'b1};

endpackage

// File: rtl/vst_edge_det.sv
module vst_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);

  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

endmodule

// File: rtl/vst_slot_ctrl.sv
module vst_slot_ctrl
  import vst_pkg::*;
#(
  parameter int unsigned INIT_PULSES = 9,
  parameter int unsigned DATA_W      = 8,
  localparam int unsigned CNT_W      = $clog2(INIT_PULSES + 1),
  localparam int unsigned SLOT_W     = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rise_i,
  output logic              step_o,
  output logic [SLOT_W-1:0] next_slot_o
);

  localparam logic [SLOT_W-1:0] GAP_SLOT  = SLOT_W'(DATA_W);
  localparam logic [CNT_W-1:0]  SYNC_LAST = CNT_W'(INIT_PULSES - 1);

  vst_phase_e        phase_q;
  logic [CNT_W-1:0]  sync_cnt_q;
  logic [SLOT_W-1:0] slot_q;

  assign step_o      = en_i & rise_i & (phase_q == PH_STREAM);
  // slot_q parks on the gap slot so the first stream step lands on slot 0
  assign next_slot_o = (slot_q == GAP_SLOT) ? '0 : slot_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_SYNC;
      sync_cnt_q <= '0;
      slot_q     <= GAP_SLOT;
    end else if (!en_i) begin
      phase_q    <= PH_SYNC;
      sync_cnt_q <= '0;
      slot_q     <= GAP_SLOT;
    end else if (rise_i) begin
      if (phase_q == PH_SYNC) begin
        sync_cnt_q <= sync_cnt_q + 1'b1;
        if (sync_cnt_q == SYNC_LAST) phase_q <= PH_STREAM;
      end else begin
        slot_q <= next_slot_o;
      end
    end
  end

endmodule

// File: rtl/vst_addr_ctr.sv
module vst_addr_ctr #(
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (inc_i)  addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/vclk_stream_tx.sv
module vclk_stream_tx
  import vst_pkg::*;
#(
  parameter int unsigned DEPTH       = 128,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned INIT_PULSES = 9,
  localparam int unsigned ADDR_W     = $clog2(DEPTH),
  localparam int unsigned SLOT_W     = $clog2(DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vclk_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              sda_o,
  output logic              sda_oe_o
);

  localparam logic [SLOT_W-1:0] GAP_SLOT = SLOT_W'(DATA_W);

  logic              vclk_rise;
  logic              step;
  logic [SLOT_W-1:0] next_slot;
  logic              gap_step;
  logic [DATA_W-1:0] shifted;
  vst_drive_t        drive_d, drive_q;

  vst_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (vclk_i),
    .rise_o (vclk_rise)
  );

  vst_slot_ctrl #(
    .INIT_PULSES (INIT_PULSES),
    .DATA_W      (DATA_W)
  ) u_slot (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .rise_i      (vclk_rise),
    .step_o      (step),
    .next_slot_o (next_slot)
  );

  assign gap_step = step & (next_slot == GAP_SLOT);

  vst_addr_ctr #(
    .DEPTH (DEPTH)
  ) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~en_i),
    .inc_i  (gap_step),
    .addr_o (rd_addr_o)
  );

  // MSB-first bit pick without a variable-width index
  assign shifted = rd_data_i << next_slot;

  always_comb begin
    drive_d = drive_q;
    if (!en_i) begin
      drive_d = DRIVE_RELEASED;
    end else if (step) begin
      if (next_slot == GAP_SLOT) drive_d = DRIVE_RELEASED;
      else                       drive_d = '{oe: 1'b1, val: shifted[DATA_W-1]};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_q <= DRIVE_RELEASED;
    else         drive_q <= drive_d;
  end

  assign sda_o    = drive_q.val;
  assign sda_oe_o = drive_q.oe;

endmodule

// File: rtl/vclk_stream_tx_chk.sv
module vclk_stream_tx_chk #(
  parameter int unsigned DEPTH  = 128,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vclk_i,
  input logic              en_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              sda_o,
  input logic              sda_oe_o
);

  logic vclk_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vclk_prev <= 1'b0;
    else         vclk_prev <= vclk_i;
  end

  AST_RELEASE_ON_DISABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sda_oe_o); // R9

  AST_DRIVE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> $past(en_i)); // R10

  AST_HOLD_WITHOUT_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(vclk_i && !vclk_prev)) |=> ($stable(sda_o) && $stable(sda_oe_o))); // R8

  AST_ADDR_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && rd_addr_o != $past(rd_addr_o)) |->
      rd_addr_o == (($past(rd_addr_o) == ADDR_W'(DEPTH - 1)) ? '0 : $past(rd_addr_o) + 1'b1)); // R6

  AST_ADDR_STEP_IN_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_o != $past(rd_addr_o)) |-> !sda_oe_o); // R5

endmodule

bind vclk_stream_tx vclk_stream_tx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vclk_i    (vclk_i),
  .en_i      (en_i),
  .rd_addr_o (rd_addr_o),
  .sda_o     (sda_o),
  .sda_oe_o  (sda_oe_o)
);

// File: tb/vclk_stream_tx_tb_top.sv
`timescale 1ns/1ps
module vclk_stream_tx_tb_top;

  localparam int DEPTH = 128;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       vclk_i = 1'b0;
  logic       en_i = 1'b0;
  logic [7:0] rd_data;
  logic [6:0] rd_addr;
  logic       sda_o, sda_oe_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  function automatic logic [7:0] mem_f(input logic [6:0] a);
    return ({1'b0, a} * 8'd29) ^ 8'hA5;
  endfunction

  assign rd_data = mem_f(rd_addr);

  vclk_stream_tx dut_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vclk_i    (vclk_i),
    .en_i      (en_i),
    .rd_data_i (rd_data),
    .rd_addr_o (rd_addr),
    .sda_o     (sda_o),
    .sda_oe_o  (sda_oe_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one VCLK pulse; returns outputs one clock after the rise, re-checks after the fall
  task automatic vpulse(output logic oe, output logic d, output logic [6:0] a);
    @(negedge clk_i) vclk_i = 1'b1;
    @(negedge clk_i);
    oe = sda_oe_o; d = sda_o; a = rd_addr;
    repeat (2) @(negedge clk_i);
    vclk_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(sda_oe_o === oe && sda_o === d, "R8 hold", {sda_oe_o, sda_o}, {oe, d});
  endtask

  task automatic t_reset();
    chk(sda_oe_o === 1'b0, "R1 oe", sda_oe_o, 0);
    chk(sda_o === 1'b1, "R1 sda", sda_o, 1);
    chk(rd_addr === 7'd0, "R1 addr", rd_addr, 0);
  endtask

  task automatic t_init(input string tag);
    logic oe, d; logic [6:0] a;
    for (int i = 0; i < 9; i++) begin
      vpulse(oe, d, a);
      chk(oe === 1'b0, {"R2 init ", tag}, oe, 0);
    end
  endtask

  task automatic t_byte(input int exp_addr, input bit first);
    logic oe, d; logic [6:0] a;
    logic [7:0] v = mem_f(7'(exp_addr));
    int nxt = (exp_addr + 1) % DEPTH;
    for (int b = 0; b < 8; b++) begin
      vpulse(oe, d, a);
      if (first && b == 0) begin
        chk(oe === 1'b1, "R3 first oe", oe, 1);
        chk(d === v[7], "R3 first msb", d, v[7]);
      end else begin
        chk(oe === 1'b1 && d === v[7-b], "R4 bit", {oe, d}, {1'b1, v[7-b]});
      end
      chk(a === 7'(exp_addr), "R4 addr hold", a, exp_addr);
    end
    vpulse(oe, d, a);
    chk(oe === 1'b0 && d === 1'b1, "R5 gap", {oe, d}, 2'b01);
    if (exp_addr == DEPTH - 1) chk(a === 7'(nxt), "R7 wrap", a, nxt);
    else                       chk(a === 7'(nxt), "R6 step", a, nxt);
  endtask

  task automatic t_reentry();
    logic oe, d; logic [6:0] a;
    for (int b = 0; b < 3; b++) vpulse(oe, d, a);
    @(negedge clk_i) en_i = 1'b0;
    @(negedge clk_i);
    chk(sda_oe_o === 1'b0, "R9 release", sda_oe_o, 0);
    chk(rd_addr === 7'd0, "R9 addr clear", rd_addr, 0);
    for (int i = 0; i < 12; i++) begin
      vpulse(oe, d, a);
      chk(oe === 1'b0 && a === 7'd0, "R10 disabled", {oe, a}, 0);
    end
    @(negedge clk_i) en_i = 1'b1;
    t_init("reentry");
    t_byte(0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    en_i = 1'b1;
    @(negedge clk_i);
    t_init("entry");
    t_byte(0, 1'b1);
    for (int k = 1; k < DEPTH; k++) t_byte(k, 1'b0);
    t_byte(0, 1'b0);
    t_byte(1, 1'b0);
    t_reentry();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule